// File: doc/BRIEF.md
# Power-Up Configuration Table Loader

This block fills a bank of volatile 8-bit configuration registers from a one-time-programmable store when power comes up. The store holds four user tables of sixteen bytes each. The first clock edge after the power-on reset is released latches a boot strap. The strap selects serial-bus mode, which always loads table 0, or pin-select mode, in which two select pins name the table. The strap and the chosen table then stay fixed until the next power-on reset. The sequencer then copies the chosen table into the register bank at one byte per clock and raises a completion flag. No host action is needed.

Once the copy has ended, a host port can rewrite the configuration registers and read them back. A status word at the address just past the table reports the latched mode, the completion flag and the loaded table index. A separate burn port models fuse programming. A burn can only clear bits in a stored byte, so a cell that has been cleared can never return to 1. The store keeps its contents through power-on resets.

Top module: `cfg_boot_loader`

## Requirements
- R1: `load_done_o` is low while reset is asserted and after it is released. It rises after exactly 17 rising clock edges counted from the reset release (1 sampling edge, then 16 copy edges). It stays high until the next power-on reset.
- R2: The strap is sampled on the first rising edge after reset release: 1 selects pin-select mode and 0 selects serial-bus mode. Later strap changes have no effect until the next power-on reset.
- R3: In serial-bus mode table 0 is loaded, whatever value the select pins carry.
- R4: In pin-select mode the select pins (values 0 to 3) are sampled on the same edge as the strap and pick the table. Later changes on them neither reload the bank nor alter the reported index.
- R5: When loading is complete, configuration register k (k = 0..15) holds byte k of the chosen table. Byte k of table t is store cell t*16+k.
- R6: An unburned store cell reads 0xFF, and store contents are kept across power-on resets.
- R7: A burn sets the addressed cell to its old value AND the burn data. A burn data bit of 1 leaves that cell bit unchanged, so no bit can go from 0 back to 1.
- R8: With `load_done_o` high, a host write to address 0..15 takes effect on the next rising edge. Reads of `host_rdata_o` are combinational on `host_addr_i`.
- R9: Host writes issued while `load_done_o` is low are ignored.
- R10: Address 16 reads the status word: bit 7 = mode (1 = pin-select), bit 6 = load done, bits 1:0 = loaded table index, other bits 0. Writes to address 16 are ignored. Addresses 17..31 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| strap_pin_mode_i | input | 1 | Boot strap: 1 pin-select mode, 0 serial-bus mode |
| tbl_sel_i | input | 2 | Table select pins used in pin-select mode |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 5 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for `host_addr_i` |
| burn_en_i | input | 1 | Burn strobe for the store |
| burn_addr_i | input | 6 | Store cell to burn (table*16 + byte) |
| burn_data_i | input | 8 | Burn pattern; 0 bits clear the cell bits |
| load_done_o | output | 1 | Table copy complete |

## Verification
The bench builds the block with its default parameters: 8-bit words and 16-byte tables, which makes a 64-cell store. At that size every byte of all four tables can be burned with a distinct pattern and read back after a power cycle, so each table-selection path is separated from the others byte by byte. The 17-edge boot window is short enough to place a host write in the middle of the copy, on a register that has already been filled, and to count the completion edge exactly.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int CFG_NUM_TABLES = 4;
  localparam int CFG_TBL_W      = $clog2(CFG_NUM_TABLES);

  typedef enum logic [1:0] {
    SEQ_SAMPLE = 2'd0,
    SEQ_COPY   = 2'd1,
    SEQ_READY  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cfgl_otp_array.sv
module cfgl_otp_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              burn_en,
  input  logic [AW-1:0]     burn_addr,
  input  logic [DATA_W-1:0] burn_data,
  output logic [DATA_W-1:0] burn_cur
);
  // Non-volatile cells: blank state is all ones, untouched by power-on reset.
  logic [DATA_W-1:0] cell_q [DEPTH] = '{default: '1};

  function automatic logic [DATA_W-1:0] fuse_merge(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] pat);
    return old_v & pat;
  endfunction

  always_ff @(posedge clk) begin
    if (burn_en) cell_q[burn_addr] <= fuse_merge(cell_q[burn_addr], burn_data);
  end

  assign rd_data  = cell_q[rd_addr];
  assign burn_cur = cell_q[burn_addr];
endmodule

// File: rtl/cfgl_boot_seq.sv
module cfgl_boot_seq
  import cfgl_pkg::*;
#(
  parameter int WORDS  = 16,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_i,
  input  logic [CFG_TBL_W-1:0] sel_i,
  output logic                 pin_mode_o,
  output logic [CFG_TBL_W-1:0] tbl_o,
  output logic                 sample_o,
  output logic                 copy_en_o,
  output logic [WORD_W-1:0]    copy_idx_o,
  output logic                 done_o
);
  localparam logic [WORD_W-1:0] LAST_IDX = WORD_W'(WORDS - 1);

  seq_state_e           state_q;
  logic                 pin_mode_q;
  logic [CFG_TBL_W-1:0] tbl_q;
  logic [WORD_W-1:0]    idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_SAMPLE;
      pin_mode_q <= 1'b0;
      tbl_q      <= '0;
      idx_q      <= '0;
    end else begin
      unique case (state_q)
        SEQ_SAMPLE: begin
          pin_mode_q <= strap_i;
          tbl_q      <= strap_i ? sel_i : '0;
          idx_q      <= '0;
          state_q    <= SEQ_COPY;
        end
        SEQ_COPY: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= SEQ_READY;
        end
        default: state_q <= SEQ_READY;
      endcase
    end
  end

  assign pin_mode_o = pin_mode_q;
  assign tbl_o      = tbl_q;
  assign sample_o   = (state_q == SEQ_SAMPLE);
  assign copy_en_o  = (state_q == SEQ_COPY);
  assign copy_idx_o = idx_q;
  assign done_o     = (state_q == SEQ_READY);
endmodule

// File: rtl/cfgl_reg_bank.sv
module cfgl_reg_bank #(
  parameter int DATA_W = 8,
  parameter int WORDS  = 16,
  parameter int AW     = 5,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              copy_en,
  input  logic [WORD_W-1:0] copy_idx,
  input  logic [DATA_W-1:0] copy_data,
  input  logic              host_we,
  input  logic              host_open,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [WORD_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              host_accept
);
  logic [DATA_W-1:0] reg_q [WORDS];

  assign host_accept = host_we && host_open && (host_addr < AW'(WORDS));

  for (genvar k = 0; k < WORDS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[k] <= '0;
      end else if (copy_en && (copy_idx == WORD_W'(k))) begin
        reg_q[k] <= copy_data;
      end else if (host_accept && (host_addr == AW'(k))) begin
        reg_q[k] <= host_wdata;
      end
    end
  end

  assign rd_data = reg_q[rd_idx];
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfgl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TABLE_WORDS = 16,
  localparam int WORD_W     = $clog2(TABLE_WORDS),
  localparam int OTP_DEPTH  = CFG_NUM_TABLES * TABLE_WORDS,
  localparam int OTP_AW     = $clog2(OTP_DEPTH),
  localparam int RAM_AW     = $clog2(TABLE_WORDS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_pin_mode_i,
  input  logic [CFG_TBL_W-1:0] tbl_sel_i,
  input  logic                 host_we_i,
  input  logic [RAM_AW-1:0]    host_addr_i,
  input  logic [DATA_W-1:0]    host_wdata_i,
  output logic [DATA_W-1:0]    host_rdata_o,
  input  logic                 burn_en_i,
  input  logic [OTP_AW-1:0]    burn_addr_i,
  input  logic [DATA_W-1:0]    burn_data_i,
  output logic                 load_done_o
);
  localparam logic [RAM_AW-1:0] STATUS_ADDR = RAM_AW'(TABLE_WORDS);

  function automatic logic [OTP_AW-1:0] otp_index(input logic [CFG_TBL_W-1:0] t,
                                                  input logic [WORD_W-1:0] w);
    return {t, w};
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic pm, input logic dn,
                                                    input logic [CFG_TBL_W-1:0] t);
    logic [DATA_W-1:0] s;
    s = '0;
    s[DATA_W-1]      = pm;
    s[DATA_W-2]      = dn;
    s[CFG_TBL_W-1:0] = t;
    return s;
  endfunction

  // Named internal events, observed by the bound checker.
  logic                 boot_sample;
  logic                 pin_mode;
  logic [CFG_TBL_W-1:0] tbl_idx;
  logic                 copy_fire;
  logic [WORD_W-1:0]    copy_idx;
  logic                 load_done;
  logic [DATA_W-1:0]    otp_word;
  logic [DATA_W-1:0]    burn_cur;
  logic [DATA_W-1:0]    bank_rd;
  logic                 host_wr_accept;

  cfgl_boot_seq #(.WORDS(TABLE_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_i    (strap_pin_mode_i),
    .sel_i      (tbl_sel_i),
    .pin_mode_o (pin_mode),
    .tbl_o      (tbl_idx),
    .sample_o   (boot_sample),
    .copy_en_o  (copy_fire),
    .copy_idx_o (copy_idx),
    .done_o     (load_done)
  );

  cfgl_otp_array #(.DATA_W(DATA_W), .DEPTH(OTP_DEPTH)) u_otp (
    .clk       (clk),
    .rd_addr   (otp_index(tbl_idx, copy_idx)),
    .rd_data   (otp_word),
    .burn_en   (burn_en_i),
    .burn_addr (burn_addr_i),
    .burn_data (burn_data_i),
    .burn_cur  (burn_cur)
  );

  cfgl_reg_bank #(.DATA_W(DATA_W), .WORDS(TABLE_WORDS), .AW(RAM_AW)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .copy_en     (copy_fire),
    .copy_idx    (copy_idx),
    .copy_data   (otp_word),
    .host_we     (host_we_i),
    .host_open   (load_done),
    .host_addr   (host_addr_i),
    .host_wdata  (host_wdata_i),
    .rd_idx      (host_addr_i[WORD_W-1:0]),
    .rd_data     (bank_rd),
    .host_accept (host_wr_accept)
  );

  always_comb begin
    if (host_addr_i < STATUS_ADDR)       host_rdata_o = bank_rd;
    else if (host_addr_i == STATUS_ADDR) host_rdata_o = status_word(pin_mode, load_done, tbl_idx);
    else                                 host_rdata_o = '0;
  end

  assign load_done_o = load_done;
endmodule

// File: rtl/cfg_boot_loader_checker.sv
module cfg_boot_loader_checker #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 4,
  parameter int TBL_W  = 2,
  parameter int OTP_AW = 6,
  parameter int RAM_AW = 5,
  parameter int WORDS  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boot_sample,
  input logic              pin_mode,
  input logic [TBL_W-1:0]  tbl_idx,
  input logic              copy_fire,
  input logic [WORD_W-1:0] copy_idx,
  input logic              load_done,
  input logic              burn_en,
  input logic [OTP_AW-1:0] burn_addr,
  input logic [DATA_W-1:0] burn_cur,
  input logic [RAM_AW-1:0] host_addr,
  input logic [DATA_W-1:0] host_rdata
);
  localparam logic [WORD_W-1:0] LAST = WORD_W'(WORDS - 1);

  assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_sample |=> $stable(pin_mode) && $stable(tbl_idx));

  assert_bus_table0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_sample && !pin_mode) |-> (tbl_idx == '0));

  assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);

  assert_done_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> ($past(copy_fire) && ($past(copy_idx) == LAST)));

  assert_copy_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_fire && (copy_idx != LAST)) |=> (copy_fire && (copy_idx == WORD_W'($past(copy_idx) + 1'b1))));

  assert_burn_clears_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burn_en |=> ((burn_addr != $past(burn_addr)) || ((burn_cur & ~$past(burn_cur)) == '0)));

  assert_status_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == RAM_AW'(WORDS)) |-> ((host_rdata[DATA_W-1] == pin_mode) &&
                                       (host_rdata[DATA_W-2] == load_done) &&
                                       (host_rdata[TBL_W-1:0] == tbl_idx)));
endmodule

bind cfg_boot_loader cfg_boot_loader_checker #(
  .DATA_W (DATA_W),
  .WORD_W (WORD_W),
  .TBL_W  (cfgl_pkg::CFG_TBL_W),
  .OTP_AW (OTP_AW),
  .RAM_AW (RAM_AW),
  .WORDS  (TABLE_WORDS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .boot_sample (boot_sample),
  .pin_mode    (pin_mode),
  .tbl_idx     (tbl_idx),
  .copy_fire   (copy_fire),
  .copy_idx    (copy_idx),
  .load_done   (load_done),
  .burn_en     (burn_en_i),
  .burn_addr   (burn_addr_i),
  .burn_cur    (burn_cur),
  .host_addr   (host_addr_i),
  .host_rdata  (host_rdata_o)
);

// File: tb/cfg_boot_loader_test.sv
module cfg_boot_loader_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic [1:0] sel = 2'd3;
  logic       host_we = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       burn_en = 1'b0;
  logic [5:0] burn_addr = '0;
  logic [7:0] burn_data = '0;
  logic       load_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] otp_model [64];

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #4 clk = ~clk;

  cfg_boot_loader uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .strap_pin_mode_i (strap),
    .tbl_sel_i        (sel),
    .host_we_i        (host_we),
    .host_addr_i      (host_addr),
    .host_wdata_i     (host_wdata),
    .host_rdata_o     (host_rdata),
    .burn_en_i        (burn_en),
    .burn_addr_i      (burn_addr),
    .burn_data_i      (burn_data),
    .load_done_o      (load_done)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares the read port, 2 ns after each falling edge.
  always @(negedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      chk(host_rdata === it.exp, it.tag, int'(host_rdata), int'(it.exp));
    end
  end

  // Driver: present an address and queue the expected read value.
  task automatic expect_rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    host_addr = a;
    sbq.push_back('{exp: e, tag: tag});
    tick(1);
  endtask

  task automatic host_wr(input logic [4:0] a, input logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    tick(1);
    host_we = 1'b0;
  endtask

  task automatic burn(input logic [5:0] a, input logic [7:0] d);
    burn_en = 1'b1; burn_addr = a; burn_data = d;
    tick(1);
    burn_en = 1'b0;
    otp_model[a] = otp_model[a] & d;
  endtask

  task automatic power_cycle(input logic s, input logic [1:0] t);
    rst_n = 1'b0; strap = s; sel = t;
    tick(2);
    chk(load_done === 1'b0, "R1", int'(load_done), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_done_exact();
    tick(16);
    chk(load_done === 1'b0, "R1", int'(load_done), 0);
    tick(1);
    chk(load_done === 1'b1, "R1", int'(load_done), 1);
  endtask

  task automatic check_table(input int t, input string tag);
    for (int k = 0; k < 16; k++) expect_rd(5'(k), otp_model[t*16 + k], tag);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) otp_model[i] = 8'hFF;
    tick(1);
    // First power-up: blank store, bus mode with select pins at 3.
    power_cycle(1'b0, 2'd3);
    wait_done_exact();
    expect_rd(5'd16, 8'h40, "R10 R3");
    check_table(0, "R6");

    // Program all four tables with distinct patterns.
    for (int a = 0; a < 64; a++) burn(6'(a), 8'((a * 37 + 11) ^ (a << 2)));
    burn(6'd3, 8'hFF);          // R7: all-ones pattern changes nothing
    burn(6'd4, 8'hF0);          // R7: clears the low nibble only
    burn(6'd4, 8'hFF);          // R7: cannot restore cleared bits

    // Bus mode, select = 2: table 0, with a write attempted during the copy.
    rst_n = 1'b0; strap = 1'b0; sel = 2'd2;
    tick(2);
    rst_n = 1'b1;
    tick(9);
    host_we = 1'b1; host_addr = 5'd0; host_wdata = ~otp_model[0];
    tick(1);
    host_we = 1'b0;
    tick(6);
    chk(load_done === 1'b0, "R1", int'(load_done), 0);
    tick(1);
    chk(load_done === 1'b1, "R1", int'(load_done), 1);
    expect_rd(5'd0, otp_model[0], "R9");
    check_table(0, "R3 R5 R6 R7");
    expect_rd(5'd16, 8'h40, "R10 R3");

    // Strap and select changes after sampling are ignored.
    strap = 1'b1; sel = 2'd1;
    tick(3);
    expect_rd(5'd16, 8'h40, "R2");
    expect_rd(5'd7, otp_model[7], "R2");

    // Host writes after completion.
    host_wr(5'd5, 8'hA5);
    expect_rd(5'd5, 8'hA5, "R8");
    host_wr(5'd15, 8'h3C);
    expect_rd(5'd15, 8'h3C, "R8");
    expect_rd(5'd14, otp_model[14], "R8");
    host_wr(5'd16, 8'h00);
    expect_rd(5'd16, 8'h40, "R10");
    expect_rd(5'd17, 8'h00, "R10");
    expect_rd(5'd31, 8'h00, "R10");

    // Pin mode, table 2; later select change ignored.
    power_cycle(1'b1, 2'd2);
    wait_done_exact();
    expect_rd(5'd16, 8'hC2, "R4 R2 R10");
    check_table(2, "R4 R5");
    sel = 2'd0; strap = 1'b0;
    tick(4);
    expect_rd(5'd16, 8'hC2, "R4");
    expect_rd(5'd9, otp_model[2*16 + 9], "R4");

    // Pin mode, boundary selects 3 and 0, then 1.
    power_cycle(1'b1, 2'd3);
    wait_done_exact();
    expect_rd(5'd16, 8'hC3, "R4 R10");
    check_table(3, "R4 R5");
    power_cycle(1'b1, 2'd0);
    wait_done_exact();
    expect_rd(5'd16, 8'hC0, "R4 R10");
    check_table(0, "R4 R5");
    power_cycle(1'b1, 2'd1);
    wait_done_exact();
    expect_rd(5'd16, 8'hC1, "R4 R10");
    check_table(1, "R4 R5");

    tick(2);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule